// File: doc/BRIEF.md
# Boot Configuration Loader

This block runs once after reset is released. It loads two user configuration bytes into holding registers before the processor core starts. A static strap selects where the bytes come from. When the strap is low, the block reads them from the top of the external 24-bit address space through a byte-wide read port. When the strap is high, it reads them from an on-chip configuration port and issues no external reads. Both ports use the same request/ready handshake.

In external mode, the first configuration byte is read twice. A port pin is sampled during the first of these reads, and its level chooses between page and non-page multiplexing for the external bus for all later traffic. Only the second read of byte 0 is kept. When the second byte has been latched, the block raises a one-cycle done pulse. It then stays idle until the next reset. Before the load finishes, the holding registers read all ones, which is the slowest and safest setting.

Top module: `boot_cfg_loader`

## Requirements
- R1: While reset is active and directly after it, both configuration outputs read 8'hFF, the page flag reads 0 and done reads 0.
- R2: With the strap low, exactly three external reads are made, at addresses 24'hFFFFF8, 24'hFFFFF8 and 24'hFFFFF9 in that order, and the on-chip port is never requested.
- R3: In external mode, the byte 0 output keeps the data of the second read of address 24'hFFFFF8, not the first.
- R4: With the strap high, exactly two on-chip reads are made, with select 0 (byte 0) and then select 1 (byte 1). No external request is made, and the page flag stays 0.
- R5: In external mode, the page flag is set to 1 when the pin is low, and to 0 when it is high, at the handshake of the first read. Later changes of the pin have no effect.
- R6: A request holds its address and select steady until ready is seen. Data is taken only on a cycle in which request and ready are both high.
- R7: Done is high for exactly one cycle, and that is the first cycle in which the byte 1 output shows the fetched value.
- R8: After done, no further request is raised. The outputs keep their values, even if ready pulses arrive, until the next reset.
- R9: Bit 7 of the byte 0 output always reads 1, whatever value was fetched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_strap_i | input | 1 | Source strap: 0 external bus, 1 on-chip store |
| pin_sense_i | input | 1 | Port pin sampled at the first byte 0 read |
| ext_req_o | output | 1 | External read request |
| ext_addr_o | output | 24 | External read address |
| ext_rdy_i | input | 1 | External read data valid |
| ext_data_i | input | 8 | External read data |
| int_req_o | output | 1 | On-chip store read request |
| int_sel_o | output | 1 | On-chip byte select (0 byte 0, 1 byte 1) |
| int_rdy_i | input | 1 | On-chip read data valid |
| int_data_i | input | 8 | On-chip read data |
| cfg0_o | output | 8 | Held configuration byte 0 |
| cfg1_o | output | 8 | Held configuration byte 1 |
| page_mode_o | output | 1 | 1 selects page multiplexing on the external bus |
| done_o | output | 1 | One-cycle pulse when loading completes |

## Verification
The loader is driven in both strap settings and with ready latencies from zero to three cycles, with the pin both low and high. In external mode the two byte 0 reads return different data, which shows whether the first or the second read is kept. The pin is inverted right after the first read, which shows whether it is sampled once or continuously. All-zero and all-ones byte values separate forcing of the reserved bit from a plain copy of the fetched data. After completion, stray ready pulses carrying zero data show whether the idle state can be disturbed.

// File: rtl/boot_cfg_pkg.sv
package boot_cfg_pkg;
  localparam int unsigned CFG_W = 8;

  typedef enum logic [1:0] {
    ST_B0_FIRST = 2'd0,
    ST_B0_AGAIN = 2'd1,
    ST_B1       = 2'd2,
    ST_END      = 2'd3
  } step_e;

  // next step after a completed transfer; on-chip source skips the repeat
  function automatic step_e next_step(input step_e cur, input logic on_chip);
    case (cur)
      ST_B0_FIRST: next_step = on_chip ? ST_B1 : ST_B0_AGAIN;
      ST_B0_AGAIN: next_step = ST_B1;
      default:     next_step = ST_END;
    endcase
  endfunction

  // reserved top bit of byte 0 always reads as one
  function automatic logic [CFG_W-1:0] keep_reserved(input logic [CFG_W-1:0] d);
    keep_reserved = d | {1'b1, {(CFG_W-1){1'b0}}};
  endfunction
endpackage

// File: rtl/bcl_seq.sv
module bcl_seq
  import boot_cfg_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  on_chip,
  input  logic  xfer,
  output step_e step,
  output logic  busy,
  output logic  ev_first,
  output logic  ev_cfg0,
  output logic  ev_cfg1
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    step <= ST_B0_FIRST;
    else if (xfer) step <= next_step(step, on_chip);
  end

  always_comb begin
    busy     = (step != ST_END);
    ev_first = xfer && (step == ST_B0_FIRST) && !on_chip;
    ev_cfg0  = xfer && ((step == ST_B0_AGAIN) || ((step == ST_B0_FIRST) && on_chip));
    ev_cfg1  = xfer && (step == ST_B1);
  end
endmodule

// File: rtl/bcl_port_mux.sv
module bcl_port_mux
  import boot_cfg_pkg::*;
#(
  parameter int unsigned        ADDR_W = 24,
  parameter int unsigned        DATA_W = 8,
  parameter logic [ADDR_W-1:0]  BASE   = 24'hFFFFF8
) (
  input  logic              on_chip,
  input  logic              busy,
  input  step_e             step,
  output logic              ext_req,
  output logic [ADDR_W-1:0] ext_addr,
  input  logic              ext_rdy,
  input  logic [DATA_W-1:0] ext_data,
  output logic              int_req,
  output logic              int_sel,
  input  logic              int_rdy,
  input  logic [DATA_W-1:0] int_data,
  output logic              xfer,
  output logic [DATA_W-1:0] rd_data
);
  function automatic logic [ADDR_W-1:0] cfg_addr(input logic idx);
    cfg_addr = BASE + {{(ADDR_W-1){1'b0}}, idx};
  endfunction

  logic byte_sel;

  always_comb begin
    byte_sel = (step == ST_B1);
    ext_req  = busy && !on_chip;
    int_req  = busy && on_chip;
    ext_addr = cfg_addr(byte_sel);
    int_sel  = byte_sel;
    xfer     = (ext_req && ext_rdy) || (int_req && int_rdy);
    rd_data  = on_chip ? int_data : ext_data;
  end
endmodule

// File: rtl/bcl_hold.sv
module bcl_hold
  import boot_cfg_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_first,
  input  logic              ev_cfg0,
  input  logic              ev_cfg1,
  input  logic              pin,
  input  logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] cfg0,
  output logic [DATA_W-1:0] cfg1,
  output logic              page,
  output logic              done
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg0 <= '1;
      cfg1 <= '1;
      page <= 1'b0;
      done <= 1'b0;
    end else begin
      if (ev_cfg0)  cfg0 <= keep_reserved(rd_data);
      if (ev_cfg1)  cfg1 <= rd_data;
      if (ev_first) page <= ~pin;
      done <= ev_cfg1;
    end
  end
endmodule

// File: rtl/boot_cfg_loader.sv
module boot_cfg_loader
  import boot_cfg_pkg::*;
#(
  parameter int unsigned       ADDR_W = 24,
  parameter int unsigned       DATA_W = CFG_W,
  parameter logic [ADDR_W-1:0] BASE   = 24'hFFFFF8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_strap_i,
  input  logic              pin_sense_i,
  output logic              ext_req_o,
  output logic [ADDR_W-1:0] ext_addr_o,
  input  logic              ext_rdy_i,
  input  logic [DATA_W-1:0] ext_data_i,
  output logic              int_req_o,
  output logic              int_sel_o,
  input  logic              int_rdy_i,
  input  logic [DATA_W-1:0] int_data_i,
  output logic [DATA_W-1:0] cfg0_o,
  output logic [DATA_W-1:0] cfg1_o,
  output logic              page_mode_o,
  output logic              done_o
);
  step_e             step;
  logic              busy;
  logic              xfer;
  logic              ev_first;
  logic              ev_cfg0;
  logic              ev_cfg1;
  logic [DATA_W-1:0] rd_data;

  bcl_seq u_seq (
    .clk(clk), .rst_n(rst_n), .on_chip(ext_strap_i), .xfer(xfer),
    .step(step), .busy(busy), .ev_first(ev_first),
    .ev_cfg0(ev_cfg0), .ev_cfg1(ev_cfg1)
  );

  bcl_port_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE(BASE)) u_mux (
    .on_chip(ext_strap_i), .busy(busy), .step(step),
    .ext_req(ext_req_o), .ext_addr(ext_addr_o), .ext_rdy(ext_rdy_i), .ext_data(ext_data_i),
    .int_req(int_req_o), .int_sel(int_sel_o), .int_rdy(int_rdy_i), .int_data(int_data_i),
    .xfer(xfer), .rd_data(rd_data)
  );

  bcl_hold #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .ev_first(ev_first), .ev_cfg0(ev_cfg0),
    .ev_cfg1(ev_cfg1), .pin(pin_sense_i), .rd_data(rd_data),
    .cfg0(cfg0_o), .cfg1(cfg1_o), .page(page_mode_o), .done(done_o)
  );
endmodule

// File: rtl/boot_cfg_loader_chk.sv
module boot_cfg_loader_chk #(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ext_req_o,
  input logic [ADDR_W-1:0] ext_addr_o,
  input logic              ext_rdy_i,
  input logic              int_req_o,
  input logic              int_sel_o,
  input logic              int_rdy_i,
  input logic [DATA_W-1:0] cfg0_o,
  input logic [DATA_W-1:0] cfg1_o,
  input logic              page_mode_o,
  input logic              done_o,
  input logic              ev_first
);
  a_r2_one_port: assert property (@(posedge clk) disable iff (!rst_n)
    !(ext_req_o && int_req_o));

  a_r6_ext_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_req_o && !ext_rdy_i) |=> (ext_req_o && $stable(ext_addr_o)));

  a_r6_int_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (int_req_o && !int_rdy_i) |=> (int_req_o && $stable(int_sel_o)));

  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r8_no_req_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!ext_req_o && !int_req_o));

  a_r8_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_req_o && !int_req_o && !done_o) |=> ($stable(cfg0_o) && $stable(cfg1_o)));

  a_r5_page_only_at_first: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_first |=> $stable(page_mode_o));

  a_r9_reserved_bit: assert property (@(posedge clk) disable iff (!rst_n)
    cfg0_o[DATA_W-1]);
endmodule

bind boot_cfg_loader boot_cfg_loader_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ext_req_o(ext_req_o), .ext_addr_o(ext_addr_o),
  .ext_rdy_i(ext_rdy_i), .int_req_o(int_req_o), .int_sel_o(int_sel_o),
  .int_rdy_i(int_rdy_i), .cfg0_o(cfg0_o), .cfg1_o(cfg1_o),
  .page_mode_o(page_mode_o), .done_o(done_o), .ev_first(ev_first)
);

// File: tb/test_boot_cfg_loader.sv
module test_boot_cfg_loader;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strap = 1'b0;
  logic        pin = 1'b0;
  logic        ext_req, int_req, int_sel, done;
  logic [23:0] ext_addr;
  logic        ext_rdy = 1'b0, int_rdy = 1'b0;
  logic [7:0]  ext_data = 8'h00, int_data = 8'h00;
  logic [7:0]  cfg0, cfg1;
  logic        page;

  boot_cfg_loader i_boot_cfg_loader (
    .clk(clk), .rst_n(rst_n), .ext_strap_i(strap), .pin_sense_i(pin),
    .ext_req_o(ext_req), .ext_addr_o(ext_addr), .ext_rdy_i(ext_rdy), .ext_data_i(ext_data),
    .int_req_o(int_req), .int_sel_o(int_sel), .int_rdy_i(int_rdy), .int_data_i(int_data),
    .cfg0_o(cfg0), .cfg1_o(cfg1), .page_mode_o(page), .done_o(done)
  );

  always #5 clk = ~clk;

  typedef struct packed {
    logic       on_chip;
    logic       pin;
    logic [1:0] lat;
    logic [7:0] d0a, d0b, d1, i0, i1;
  } vec_t;

  localparam int NV = 5;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b0, 2'd0, 8'h11, 8'h22, 8'h33, 8'h00, 8'h00},
    '{1'b0, 1'b1, 2'd2, 8'h5A, 8'h3C, 8'hC3, 8'h00, 8'h00},
    '{1'b1, 1'b0, 2'd1, 8'h44, 8'h44, 8'h44, 8'h01, 8'h7E},
    '{1'b0, 1'b0, 2'd3, 8'h00, 8'h7F, 8'h00, 8'h00, 8'h00},
    '{1'b1, 1'b1, 2'd0, 8'h00, 8'h00, 8'h00, 8'hFF, 8'h80}
  };

  int   total = 0, bad = 0;
  vec_t cur;
  int   ext_n, int_n, b0n, done_n, order_err, wcnt;
  logic toggled, stray;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // transfer monitor (R2, R4, R6 ordering)
  always @(posedge clk) begin
    if (rst_n && ext_req && ext_rdy) begin
      if (ext_addr !== ((ext_n < 2) ? 24'hFFFFF8 : 24'hFFFFF9)) order_err++;
      if (ext_addr[0] == 1'b0) b0n++;
      ext_n++;
    end
    if (rst_n && int_req && int_rdy) begin
      if (int_sel !== (int_n == 1)) order_err++;
      int_n++;
    end
  end

  // responders, plus pin flip after first byte 0 read (R5)
  always @(negedge clk) begin
    if (stray) begin
      ext_rdy <= 1'b1; ext_data <= 8'h00; int_rdy <= 1'b1; int_data <= 8'h00;
    end else begin
      if (ext_req && !ext_rdy) begin
        if (wcnt == int'(cur.lat)) begin
          ext_rdy  <= 1'b1;
          ext_data <= ext_addr[0] ? cur.d1 : ((b0n == 0) ? cur.d0a : cur.d0b);
        end else wcnt++;
      end else begin
        ext_rdy <= 1'b0;
        if (!int_req || int_rdy) wcnt = 0;
      end
      if (int_req && !int_rdy) begin
        if (wcnt == int'(cur.lat)) begin
          int_rdy  <= 1'b1;
          int_data <= int_sel ? cur.i1 : cur.i0;
        end else wcnt++;
      end else int_rdy <= 1'b0;
    end
    if (b0n >= 1 && !toggled) begin
      pin     = ~pin;
      toggled = 1'b1;
    end
    if (rst_n && done) begin
      done_n++;
      check("R7 cfg1 valid with done", {24'h0, cfg1}, {24'h0, cur.on_chip ? cur.i1 : cur.d1});
    end
  end

  task automatic start(input vec_t v);
    cur = v; ext_n = 0; int_n = 0; b0n = 0; done_n = 0; order_err = 0; wcnt = 0;
    toggled = 1'b0; stray = 1'b0;
    strap = v.on_chip; pin = v.pin;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 cfg0 reset", {24'h0, cfg0}, 32'hFF);
    check("R1 cfg1 reset", {24'h0, cfg1}, 32'hFF);
    check("R1 page/done reset", {30'h0, page, done}, 32'h0);
    rst_n = 1'b1;
  endtask

  initial begin
    for (int i = 0; i < NV; i++) begin
      logic [7:0] e0, e1;
      start(VEC[i]);
      for (int c = 0; c < 200 && done_n == 0; c++) @(negedge clk);
      repeat (4) @(negedge clk);
      e0 = (VEC[i].on_chip ? VEC[i].i0 : VEC[i].d0b) | 8'h80;
      e1 = VEC[i].on_chip ? VEC[i].i1 : VEC[i].d1;
      check(VEC[i].on_chip ? "R4 cfg0 on-chip" : "R3 cfg0 second read", {24'h0, cfg0}, {24'h0, e0});
      check("R9 reserved bit", {31'h0, cfg0[7]}, 32'h1);
      check("R2/R4 cfg1", {24'h0, cfg1}, {24'h0, e1});
      check("R5 page flag", {31'h0, page}, {31'h0, !VEC[i].on_chip && !VEC[i].pin});
      check("R2 ext read count", ext_n, VEC[i].on_chip ? 0 : 3);
      check("R4 int read count", int_n, VEC[i].on_chip ? 2 : 0);
      check("R6 address/select order", order_err, 0);
      check("R7 single done", done_n, 1);
      // R8: stray ready pulses after completion
      stray = 1'b1;
      repeat (3) @(negedge clk);
      stray = 1'b0;
      repeat (2) @(negedge clk);
      check("R8 cfg0 held", {24'h0, cfg0}, {24'h0, e0});
      check("R8 cfg1 held", {24'h0, cfg1}, {24'h0, e1});
      check("R8 no requests", {30'h0, ext_req, int_req}, 32'h0);
      check("R8 no extra done", done_n, 1);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #500000;
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule